// File: doc/BRIEF.md
# CAN FD Receive Ring Reader

This block drains a circular region of memory that an upstream receiver fills with CAN and CAN FD frames. The ring is divided into 16-byte slots, two 64-bit memory words per slot. Every message starts with a header word, followed by its payload words. A message may take one to five slots, depending on its length. The block reads the header through a one-cycle-latency read port and decodes the identifier, the frame flags, the FD option bits, the byte length and the three receiver status bits. It then fetches the payload words. If a payload runs past the last word of the ring, the word address wraps to the start of the ring. The block presents the finished message on a valid/ready output and moves its read pointer forward once the message is accepted.

The write pointer is owned by the filling process and enters as a plain input. The read pointer leaves as a plain output, so the filling process can see which slots are free. Both pointers count in slots. Back-pressure rules on the message output:

- A presented message stays unchanged while `msg_ready` is low.
- A message is consumed in the cycle where `msg_valid` and `msg_ready` are both high.
- The next header is not fetched before that cycle.

Top module: `canfd_ring_reader`

## Requirements
- R1: When `rd_ptr` equals `wr_ptr`, the ring is empty. The block then issues no memory read and presents no message. After reset, `rd_ptr` is 0 and `msg_valid` is 0.
- R2: Memory word layout and header fields:
  - The header sits at word address 2×`rd_ptr`.
  - Bits 63:32 form header word 0 and bits 31:0 form header word 1.
  - Bit 63 is the extended flag and bit 62 is the remote flag.
  - `msg_id` is bits 61:32 for an extended frame. For a standard frame it is bits 61:50, zero-extended.
- R3: `msg_fdopt` is bits 27:25, and bit 25 marks an FD frame. The DLC is bits 31:28.
  - For an FD frame, DLC 0–8 gives the same number of bytes, and DLC 9–15 gives 12, 16, 20, 24, 32, 48 and 64 bytes.
  - Otherwise `msg_len` is the DLC, clamped to 8.
- R4: Header bit 2 drives `msg_overrun`, bit 1 drives `msg_busoff` and bit 0 drives `msg_errpas`.
- R5: The payload is ceil(`msg_len`/8) words. Payload word k is read from the header address + 1 + k and appears on `msg_data[64k+63:64k]`. All higher words of `msg_data` are zero.
- R6: A payload word address that reaches 2×`ring_slots` wraps to 0. No read address is ever at or above 2×`ring_slots`.
- R7: On acceptance, `rd_ptr` advances by 1 + ((`msg_len`+7)>>4) slots. If the sum reaches `ring_slots`, `ring_slots` is subtracted.
- R8: While a message needs more slots than (`wr_ptr`−`rd_ptr`) mod `ring_slots`, the block waits. It does not present the message and `rd_ptr` stays unchanged. Once enough slots exist, the message is delivered.
- R9: While `msg_valid` is high and `msg_ready` is low, every message output and `rd_ptr` hold their values. `rd_ptr` changes only in a cycle with `msg_valid` and `msg_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_slots | input | SLOT_W+1 | Ring size in 16-byte slots |
| wr_ptr | input | SLOT_W | Producer write pointer, in slots |
| rd_ptr | output | SLOT_W | Read pointer, in slots |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | SLOT_W+1 | 64-bit word address within the ring |
| mem_rdata | input | 64 | Read data, valid the cycle after the strobe |
| msg_valid | output | 1 | Decoded message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_ext | output | 1 | Extended identifier flag |
| msg_rtr | output | 1 | Remote frame flag |
| msg_id | output | 30 | Identifier |
| msg_fdopt | output | 3 | FD option bits, bit 0 is FD frame |
| msg_len | output | 7 | Payload length in bytes |
| msg_overrun | output | 1 | Receiver overrun status |
| msg_busoff | output | 1 | Bus-off status |
| msg_errpas | output | 1 | Error-passive status |
| msg_data | output | 512 | Payload words, word 0 in bits 63:0 |

## Verification
Acceptance of a message and a move of the write pointer can happen in the same cycle. The acceptance advances `rd_ptr`, while the pointer move changes the empty and free-slot tests that the next fetch depends on. The bench provokes this by holding `msg_ready` low on a waiting message, then raising it in the same cycle that it publishes a fresh message by moving `wr_ptr`. The run is judged by the behavioural model: `rd_ptr` must match the model on every clock, and both messages must appear in order with exact fields and payload.

// File: rtl/canfd_ring_pkg.sv
package canfd_ring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CHK,
    ST_DATA,
    ST_OUT
  } rd_state_e;

  typedef struct packed {
    logic        ext;
    logic        rtr;
    logic [29:0] id;
    logic [2:0]  fdopt;
    logic [6:0]  len;
    logic [2:0]  stat;
  } msg_hdr_t;

  // Byte count from the 4-bit length code; FD frames use the stepped table.
  function automatic logic [6:0] code_to_bytes(input logic [3:0] code, input logic fd);
    logic [6:0] n;
    if (!fd) begin
      n = (code > 4'd8) ? 7'd8 : {3'b000, code};
    end else if (code <= 4'd8) begin
      n = {3'b000, code};
    end else if (code <= 4'd12) begin
      n = 7'd12 + 7'({code - 4'd9, 2'b00});
    end else if (code == 4'd13) begin
      n = 7'd32;
    end else if (code == 4'd14) begin
      n = 7'd48;
    end else begin
      n = 7'd64;
    end
    return n;
  endfunction

endpackage

// File: rtl/canfd_hdr_decode.sv
module canfd_hdr_decode
  import canfd_ring_pkg::*;
(
  input  logic [31:0] hw0,
  input  logic [6:0]  hw1_ctl,
  input  logic [2:0]  hw1_stat,
  output msg_hdr_t    hdr,
  output logic [3:0]  nwords,
  output logic [2:0]  nslots
);
  logic [7:0] len_p7;

  always_comb begin
    hdr.ext   = hw0[31];
    hdr.rtr   = hw0[30];
    hdr.id    = hw0[31] ? hw0[29:0] : {18'd0, hw0[29:18]};
    hdr.fdopt = hw1_ctl[2:0];
    hdr.len   = code_to_bytes(hw1_ctl[6:3], hw1_ctl[0]);
    hdr.stat  = hw1_stat;
    len_p7    = {1'b0, hdr.len} + 8'd7;
    nwords    = len_p7[6:3];
    nslots    = 3'd1 + len_p7[6:4];
  end
endmodule

// File: rtl/canfd_ring_ptr.sv
module canfd_ring_ptr #(
  parameter int SLOT_W = 6
) (
  input  logic [SLOT_W-1:0] rd,
  input  logic [SLOT_W-1:0] wr,
  input  logic [SLOT_W:0]   size,
  input  logic [2:0]        step,
  output logic              empty,
  output logic [SLOT_W:0]   avail,
  output logic [SLOT_W-1:0] rd_next
);
  localparam int SUM_W = SLOT_W + 2;

  logic [SLOT_W:0] rd_x, wr_x;
  logic [SUM_W-1:0] sum, size_x;

  always_comb begin
    rd_x    = {1'b0, rd};
    wr_x    = {1'b0, wr};
    empty   = (rd == wr);
    avail   = (wr_x >= rd_x) ? (wr_x - rd_x) : (size - rd_x + wr_x);
    sum     = {2'b00, rd} + SUM_W'(step);
    size_x  = {1'b0, size};
    rd_next = (sum >= size_x) ? SLOT_W'(sum - size_x) : SLOT_W'(sum);
  end
endmodule

// File: rtl/canfd_word_wrap.sv
module canfd_word_wrap #(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr,
  input  logic [AW:0]   limit,
  output logic [AW-1:0] next
);
  logic [AW:0] inc;

  always_comb begin
    inc  = {1'b0, addr} + (AW+1)'(1);
    next = (inc == limit) ? '0 : inc[AW-1:0];
  end
endmodule

// File: rtl/canfd_ring_reader.sv
module canfd_ring_reader
  import canfd_ring_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOT_W:0]     ring_slots,
  input  logic [SLOT_W-1:0]   wr_ptr,
  output logic [SLOT_W-1:0]   rd_ptr,
  output logic                mem_rd_en,
  output logic [SLOT_W:0]     mem_addr,
  input  logic [63:0]         mem_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic                msg_ext,
  output logic                msg_rtr,
  output logic [29:0]         msg_id,
  output logic [2:0]          msg_fdopt,
  output logic [6:0]          msg_len,
  output logic                msg_overrun,
  output logic                msg_busoff,
  output logic                msg_errpas,
  output logic [511:0]        msg_data
);
  localparam int AW        = SLOT_W + 1;
  localparam int MAX_WORDS = 8;
  localparam int WORD_W    = 64;
  localparam int WIDX_W    = $clog2(MAX_WORDS);

  rd_state_e state_q;
  msg_hdr_t  hdr_d, hdr_q;
  logic [3:0] nw_d, nw_q, wcnt_q;
  logic [2:0] ns_d, ns_q;
  logic [SLOT_W-1:0] rd_q, rd_next;
  logic [SLOT_W:0]   avail;
  logic              empty;
  logic [AW-1:0]     waddr_q, waddr_nx;
  logic              room_ok, more_words;
  logic [MAX_WORDS-1:0][WORD_W-1:0] data_q;

  canfd_hdr_decode u_dec (
    .hw0      (mem_rdata[63:32]),
    .hw1_ctl  (mem_rdata[31:25]),
    .hw1_stat (mem_rdata[2:0]),
    .hdr      (hdr_d),
    .nwords   (nw_d),
    .nslots   (ns_d)
  );

  canfd_ring_ptr #(.SLOT_W(SLOT_W)) u_ptr (
    .rd      (rd_q),
    .wr      (wr_ptr),
    .size    (ring_slots),
    .step    (ns_q),
    .empty   (empty),
    .avail   (avail),
    .rd_next (rd_next)
  );

  canfd_word_wrap #(.AW(AW)) u_wrap (
    .addr  (waddr_q),
    .limit ({ring_slots, 1'b0}),
    .next  (waddr_nx)
  );

  assign room_ok    = (AW'(ns_q) <= avail);
  assign more_words = ((wcnt_q + 4'd1) < nw_q);

  // Read-port requests: header in IDLE, first payload word in CHK, rest in DATA.
  always_comb begin
    mem_rd_en = 1'b0;
    mem_addr  = waddr_nx;
    unique case (state_q)
      ST_IDLE: begin
        mem_rd_en = !empty;
        mem_addr  = {rd_q, 1'b0};
      end
      ST_CHK:  mem_rd_en = room_ok && (nw_q != 4'd0);
      ST_DATA: mem_rd_en = more_words;
      default: mem_rd_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      nw_q    <= '0;
      ns_q    <= '0;
      wcnt_q  <= '0;
      rd_q    <= '0;
      waddr_q <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (!empty) begin
          waddr_q <= {rd_q, 1'b0};
          state_q <= ST_HDR;
        end
        ST_HDR: begin
          hdr_q   <= hdr_d;
          nw_q    <= nw_d;
          ns_q    <= ns_d;
          data_q  <= '0;
          state_q <= ST_CHK;
        end
        ST_CHK: if (room_ok) begin
          if (nw_q == 4'd0) begin
            state_q <= ST_OUT;
          end else begin
            waddr_q <= waddr_nx;
            wcnt_q  <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          data_q[wcnt_q[WIDX_W-1:0]] <= mem_rdata;
          if (more_words) begin
            waddr_q <= waddr_nx;
            wcnt_q  <= wcnt_q + 4'd1;
          end else begin
            state_q <= ST_OUT;
          end
        end
        ST_OUT: if (msg_ready) begin
          rd_q    <= rd_next;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_ptr      = rd_q;
  assign msg_valid   = (state_q == ST_OUT);
  assign msg_ext     = hdr_q.ext;
  assign msg_rtr     = hdr_q.rtr;
  assign msg_id      = hdr_q.id;
  assign msg_fdopt   = hdr_q.fdopt;
  assign msg_len     = hdr_q.len;
  assign msg_overrun = hdr_q.stat[2];
  assign msg_busoff  = hdr_q.stat[1];
  assign msg_errpas  = hdr_q.stat[0];
  assign msg_data    = data_q;
endmodule

// File: rtl/canfd_ring_reader_chk.sv
module canfd_ring_reader_chk #(
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W:0]   ring_slots,
  input logic [SLOT_W-1:0] wr_ptr,
  input logic [SLOT_W-1:0] rd_ptr,
  input logic              mem_rd_en,
  input logic [SLOT_W:0]   mem_addr,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [29:0]       msg_id,
  input logic [2:0]        msg_fdopt,
  input logic [6:0]        msg_len,
  input logic [511:0]      msg_data
);
  assert_empty_no_msg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (rd_ptr != wr_ptr));

  assert_len_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((msg_len <= 7'd64) && (msg_fdopt[0] || msg_len <= 7'd8)));

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_len <= 7'd8) |-> (msg_data[511:64] == '0));

  assert_addr_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ({1'b0, mem_addr} < {ring_slots, 1'b0}));

  assert_rd_in_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rd_ptr} < ring_slots));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_id) && $stable(msg_len)
                                   && $stable(msg_data) && $stable(rd_ptr)));

  assert_rd_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && msg_ready) |=> $stable(rd_ptr));
endmodule

bind canfd_ring_reader canfd_ring_reader_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ring_slots (ring_slots),
  .wr_ptr     (wr_ptr),
  .rd_ptr     (rd_ptr),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_id     (msg_id),
  .msg_fdopt  (msg_fdopt),
  .msg_len    (msg_len),
  .msg_data   (msg_data)
);

// File: tb/test_canfd_ring_reader.sv
module test_canfd_ring_reader;
  localparam int SLOT_W = 6;
  localparam int RING   = 16;

  typedef struct packed {
    logic         ext;
    logic         rtr;
    logic [29:0]  id;
    logic [2:0]   fdopt;
    logic [6:0]   len;
    logic [2:0]   stat;
    logic [511:0] data;
    logic [2:0]   slots;
  } exp_msg_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [SLOT_W:0]   ring_slots;
  logic [SLOT_W-1:0] wr_ptr, rd_ptr;
  logic              mem_rd_en;
  logic [SLOT_W:0]   mem_addr;
  logic [63:0]       mem_rdata;
  logic              msg_valid, msg_ready, msg_ext, msg_rtr;
  logic [29:0]       msg_id;
  logic [2:0]        msg_fdopt;
  logic [6:0]        msg_len;
  logic              msg_overrun, msg_busoff, msg_errpas;
  logic [511:0]      msg_data;

  canfd_ring_reader #(.SLOT_W(SLOT_W)) i_canfd_ring_reader (
    .clk(clk), .rst_n(rst_n), .ring_slots(ring_slots), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_ext(msg_ext), .msg_rtr(msg_rtr), .msg_id(msg_id),
    .msg_fdopt(msg_fdopt), .msg_len(msg_len), .msg_overrun(msg_overrun),
    .msg_busoff(msg_busoff), .msg_errpas(msg_errpas), .msg_data(msg_data)
  );

  logic [63:0] ram [0:127];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= ram[mem_addr];

  int n_checks = 0;
  int n_fail   = 0;
  int wp       = 0;
  int model_rd = 0;
  bit run      = 1'b0;
  bit done     = 1'b0;
  bit hold_pend = 1'b0;
  exp_msg_t exp_q[$];
  exp_msg_t snap;
  int fd_len [16] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 12, 16, 20, 24, 32, 48, 64};

  task automatic check(input bit ok, input string req, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // Producer: writes one message into the ring and, if asked, publishes it.
  task automatic put_msg(input bit ext, input bit rtr, input logic [29:0] id,
                         input logic [2:0] fdopt, input logic [3:0] code,
                         input logic [2:0] st, input logic [7:0] seed,
                         input bit publish);
    exp_msg_t e;
    int len, nw, ns;
    logic [31:0] w0;
    len = fdopt[0] ? fd_len[code] : ((code > 8) ? 8 : int'(code));
    nw  = (len + 7) / 8;
    ns  = 1 + (len + 7) / 16;
    w0  = ext ? {1'b1, rtr, id} : {1'b0, rtr, id[11:0], 18'h2A5A5};
    ram[2*wp] = {w0, code, fdopt, 22'd0, st};
    e = '0;
    e.ext = ext; e.rtr = rtr;
    e.id = ext ? id : {18'd0, id[11:0]};
    e.fdopt = fdopt; e.len = 7'(len); e.stat = st; e.slots = 3'(ns);
    for (int k = 0; k < nw; k++) begin
      logic [63:0] w;
      w = {seed, 24'h0, 8'(k), 24'hC0FFEE};
      ram[(2*wp + 1 + k) % (2*RING)] = w;
      e.data[64*k +: 64] = w;
    end
    exp_q.push_back(e);
    wp = (wp + ns) % RING;
    if (publish) wr_ptr = SLOT_W'(wp);
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 300) begin
      @(posedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R8", $sformatf("pending messages act=%0d exp=0", exp_q.size()));
    @(posedge clk); #1;
  endtask

  // Reference comparison on every falling edge.
  always @(negedge clk) begin
    if (run && rst_n) begin
      check(int'(rd_ptr) == model_rd, "R7",
            $sformatf("rd_ptr act=%0d exp=%0d", rd_ptr, model_rd));
      if (mem_rd_en)
        check(int'(mem_addr) < 2*RING, "R6",
              $sformatf("mem_addr act=%0d exp<%0d", mem_addr, 2*RING));
      if (hold_pend)
        check(msg_valid && msg_id == snap.id && msg_len == snap.len && msg_data == snap.data,
              "R9", $sformatf("held msg valid=%0b id act=%h exp=%h len act=%0d exp=%0d",
                             msg_valid, msg_id, snap.id, msg_len, snap.len));
      hold_pend = 1'b0;
      if (msg_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "msg_valid act=1 exp=0");
        end else begin
          exp_msg_t e;
          e = exp_q[0];
          check(msg_ext == e.ext && msg_rtr == e.rtr && msg_id == e.id, "R2",
                $sformatf("ext/rtr/id act=%0b/%0b/%h exp=%0b/%0b/%h",
                          msg_ext, msg_rtr, msg_id, e.ext, e.rtr, e.id));
          check(msg_len == e.len && msg_fdopt == e.fdopt, "R3",
                $sformatf("len/fdopt act=%0d/%0d exp=%0d/%0d", msg_len, msg_fdopt, e.len, e.fdopt));
          check({msg_overrun, msg_busoff, msg_errpas} == e.stat, "R4",
                $sformatf("status act=%b exp=%b", {msg_overrun, msg_busoff, msg_errpas}, e.stat));
          check(msg_data == e.data, "R5",
                $sformatf("data act=%h exp=%h", msg_data, e.data));
          if (msg_ready) begin
            void'(exp_q.pop_front());
            model_rd = (model_rd + int'(e.slots)) % RING;
          end else begin
            snap = e;
            hold_pend = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; msg_ready = 1'b0; wr_ptr = '0; ring_slots = (SLOT_W+1)'(RING);
    for (int i = 0; i < 128; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    check(!msg_valid && rd_ptr == '0 && !mem_rd_en, "R1",
          $sformatf("reset valid/rd/en act=%0b/%0d/%0b exp=0/0/0", msg_valid, rd_ptr, mem_rd_en));
    @(posedge clk); #1;
    rst_n = 1'b1; run = 1'b1; msg_ready = 1'b1;
    repeat (5) @(posedge clk); #1;

    // R2 standard and extended identifiers; R3 classical clamp
    put_msg(0, 0, 30'h5A3, 3'b000, 4'd3, 3'b000, 8'h11, 1); drain();
    put_msg(1, 1, 30'h2BCDEF12, 3'b000, 4'd12, 3'b000, 8'h22, 1); drain();
    // R4 status bits
    put_msg(0, 0, 30'h7FF, 3'b000, 4'd2, 3'b101, 8'h33, 1); drain();
    put_msg(1, 0, 30'h1, 3'b000, 4'd1, 3'b010, 8'h44, 1); drain();
    // R3 FD table, multi-slot R7
    put_msg(0, 0, 30'h123, 3'b011, 4'd9, 3'b000, 8'h55, 1); drain();
    put_msg(1, 0, 30'h3000_0001, 3'b001, 4'd13, 3'b000, 8'h66, 1); drain();
    // classical frames with spare option bits and short lengths
    put_msg(0, 0, 30'h0, 3'b110, 4'd0, 3'b000, 8'h77, 1); drain();
    put_msg(0, 1, 30'h456, 3'b000, 4'd1, 3'b000, 8'h78, 1); drain();
    put_msg(1, 0, 30'h15, 3'b000, 4'd5, 3'b100, 8'h79, 1); drain();
    put_msg(0, 0, 30'h789, 3'b000, 4'd7, 3'b000, 8'h7A, 1); drain();

    // R8: a 5-slot message with only one slot published; R6/R7 wrap afterwards
    put_msg(1, 0, 30'h0ABC_DEF0, 3'b011, 4'd15, 3'b001, 8'h88, 0);
    wr_ptr = SLOT_W'(14);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      check(!msg_valid && rd_ptr == SLOT_W'(13), "R8",
            $sformatf("waiting valid/rd act=%0b/%0d exp=0/13", msg_valid, rd_ptr));
    end
    @(posedge clk); #1;
    wr_ptr = SLOT_W'(wp);
    drain();

    // remaining FD lengths
    put_msg(0, 0, 30'h321, 3'b001, 4'd14, 3'b000, 8'h99, 1); drain();
    put_msg(0, 0, 30'h654, 3'b101, 4'd10, 3'b000, 8'h9A, 1); drain();
    put_msg(1, 0, 30'h77, 3'b001, 4'd11, 3'b000, 8'h9B, 1); drain();
    put_msg(0, 0, 30'h111, 3'b001, 4'd12, 3'b000, 8'h9C, 1); drain();

    // R9 back-pressure, then acceptance in the same cycle as a new publication
    msg_ready = 1'b0;
    put_msg(0, 0, 30'h2AA, 3'b000, 4'd8, 3'b000, 8'hA1, 1);
    repeat (15) @(posedge clk);
    #1;
    msg_ready = 1'b1;
    put_msg(1, 0, 30'h155, 3'b001, 4'd4, 3'b000, 8'hA2, 1);
    drain();

    // R1: empty ring stays idle
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      check(!msg_valid && !mem_rd_en && rd_ptr == wr_ptr, "R1",
            $sformatf("idle valid/en act=%0b/%0b exp=0/0", msg_valid, mem_rd_en));
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run act=hung exp=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule